// File: doc/BRIEF.md
# Accumulator Decimal Adjust and Divide Unit

This block is the accumulator-side arithmetic unit of an 8-bit processor datapath. It performs two operations, chosen by `op_i` when `start_i` is sampled high. The first is a decimal adjust. It corrects the accumulator after a plain binary add of two packed-BCD bytes, so that the result is two valid BCD digits again. The second is an unsigned divide of the accumulator by the B register. It produces a quotient and a remainder.

Decimal adjust is purely combinational and its result is registered in a single clock. The divide is a sequential restoring divider that resolves one quotient bit per clock. A zero divisor is detected up front and completes at once with the overflow flag raised. All results are registered and are held until the next operation completes. `done_o` marks each completion.

Top module: `acc_adjdiv_unit`

## Requirements
- R1: After reset `acc_o`, `breg_o`, `cy_o`, `ov_o` and `done_o` are all 0.
- R2: Operation select encoding: `op_i`=0 selects decimal adjust and `op_i`=1 selects divide.
- R3: Decimal adjust first adds 0x06 to the accumulator when bits [3:0] exceed 9 or `ac_i`=1. The result is a 9-bit intermediate.
- R4: Decimal adjust then adds 0x60 to the intermediate when `cy_i`=1, when intermediate bits [7:4] exceed 9, or when the first step carried out of bit 7. `acc_o` receives the low 8 bits.
- R5: Decimal adjust sets `cy_o` when the final 9-bit sum exceeds 0xFF and otherwise copies `cy_i`, so an incoming carry is never cleared. `breg_o` takes `breg_i` and `ov_o` keeps its previous value. The results and `done_o`=1 appear after the clock edge that samples `start_i`.
- R6: A divide with non-zero `breg_i` writes the quotient into `acc_o` and the remainder into `breg_o`, and clears `ov_o` and `cy_o`. These results and `done_o` appear after the 8th clock edge following the edge that sampled `start_i`. `done_o` stays 0 before then.
- R7: A divide with `breg_i`=0 completes after the sampling edge with `ov_o`=1 and `cy_o`=0. `acc_o` and `breg_o` equal the sampled `acc_i` and `breg_i`.
- R8: A `start_i` sampled while a divide is in progress is ignored. This covers the sampling edges from the one after acceptance up to and including the edge that raises `done_o`. Such a start changes no output and produces no extra `done_o`. A start sampled while `done_o` is high is accepted.
- R9: `done_o` is high only in the cycle after a completing edge. All result outputs hold their value until the next operation completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begins the operation chosen by op_i |
| op_i | input | 1 | 0 = decimal adjust, 1 = divide |
| acc_i | input | 8 | Accumulator operand |
| breg_i | input | 8 | B register operand (divisor) |
| cy_i | input | 1 | Incoming carry flag |
| ac_i | input | 1 | Incoming auxiliary-carry flag |
| acc_o | output | 8 | New accumulator value |
| breg_o | output | 8 | New B register value |
| cy_o | output | 1 | New carry flag |
| ov_o | output | 1 | New overflow flag |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A divide finishing and a new start can land on the same clock edge. The bench provokes this in two ways. First, it raises `start_i` on exactly the edge that completes a divide, using a zero divisor that would visibly set overflow if accepted. It then checks that the next cycle shows the divide result held and `done_o` low. Second, it raises `start_i` for a decimal adjust one cycle later, while `done_o` is high, and checks that this start is accepted. A decimal adjust start injected early in a divide is also checked to leave the quotient intact.

// File: rtl/acc_adjdiv_pkg.sv
package acc_adjdiv_pkg;
    localparam int BYTE_W = 8;
    localparam int NIB_W  = 4;
    localparam logic OP_DADJ = 1'b0;
    localparam logic OP_DIV  = 1'b1;
    localparam logic [NIB_W-1:0] DIGIT_MAX = 4'd9;
endpackage

// File: rtl/acc_adjdiv_dadj.sv
module acc_adjdiv_dadj
    import acc_adjdiv_pkg::*;
(
    input  logic [BYTE_W-1:0] acc_i,
    input  logic              cy_i,
    input  logic              ac_i,
    output logic [BYTE_W-1:0] acc_o,
    output logic              cy_o
);
    localparam int SUM_W = BYTE_W + 1;
    localparam logic [SUM_W-1:0] LO_FIX = SUM_W'(6);
    localparam logic [SUM_W-1:0] HI_FIX = SUM_W'(6) << NIB_W;

    logic [SUM_W-1:0] first_sum;
    logic [SUM_W-1:0] second_sum;
    logic             lo_need;
    logic             hi_need;

    always_comb begin
        lo_need    = ac_i || (acc_i[NIB_W-1:0] > DIGIT_MAX);
        first_sum  = {1'b0, acc_i} + (lo_need ? LO_FIX : '0);
        hi_need    = cy_i || first_sum[BYTE_W]
                     || (first_sum[BYTE_W-1:NIB_W] > DIGIT_MAX);
        second_sum = first_sum + (hi_need ? HI_FIX : '0);
        acc_o      = second_sum[BYTE_W-1:0];
        cy_o       = cy_i | second_sum[BYTE_W];
    end
endmodule

// File: rtl/acc_adjdiv_step.sv
module acc_adjdiv_step #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] rem_i,
    input  logic [DATA_W-1:0] quo_i,
    input  logic [DATA_W-1:0] dvsr_i,
    output logic [DATA_W-1:0] rem_o,
    output logic [DATA_W-1:0] quo_o
);
    logic [DATA_W:0]   partial;
    logic [DATA_W-1:0] diff_lo;
    logic              fits;

    always_comb begin
        partial = {rem_i, quo_i[DATA_W-1]};
        fits    = partial >= {1'b0, dvsr_i};
        diff_lo = partial[DATA_W-1:0] - dvsr_i;
        rem_o   = fits ? diff_lo : partial[DATA_W-1:0];
        quo_o   = {quo_i[DATA_W-2:0], fits};
    end
endmodule

// File: rtl/acc_adjdiv_unit.sv
module acc_adjdiv_unit
    import acc_adjdiv_pkg::*;
#(
    parameter int DATA_W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              op_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] breg_i,
    input  logic              cy_i,
    input  logic              ac_i,
    output logic [DATA_W-1:0] acc_o,
    output logic [DATA_W-1:0] breg_o,
    output logic              cy_o,
    output logic              ov_o,
    output logic              done_o
);
    localparam int CNT_W = $clog2(DATA_W + 1);

    typedef struct packed {
        logic              busy;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] rem;
        logic [DATA_W-1:0] quo;
        logic [DATA_W-1:0] dvsr;
        logic [DATA_W-1:0] acc;
        logic [DATA_W-1:0] breg;
        logic              cy;
        logic              ov;
        logic              done;
    } unit_state_t;

    unit_state_t state_d;
    unit_state_t state_q;

    logic [DATA_W-1:0] adj_acc;
    logic              adj_cy;
    logic [DATA_W-1:0] step_rem;
    logic [DATA_W-1:0] step_quo;
    logic              busy_w;
    logic [CNT_W-1:0]  cnt_w;

    acc_adjdiv_dadj dadj_i (
        .acc_i (acc_i),
        .cy_i  (cy_i),
        .ac_i  (ac_i),
        .acc_o (adj_acc),
        .cy_o  (adj_cy)
    );

    acc_adjdiv_step #(.DATA_W(DATA_W)) step_i (
        .rem_i  (state_q.rem),
        .quo_i  (state_q.quo),
        .dvsr_i (state_q.dvsr),
        .rem_o  (step_rem),
        .quo_o  (step_quo)
    );

    always_comb begin
        state_d      = state_q;
        state_d.done = 1'b0;
        if (state_q.busy) begin
            state_d.rem = step_rem;
            state_d.quo = step_quo;
            state_d.cnt = state_q.cnt - 1'b1;
            if (state_q.cnt == CNT_W'(1)) begin
                state_d.busy = 1'b0;
                state_d.acc  = step_quo;
                state_d.breg = step_rem;
                state_d.cy   = 1'b0;
                state_d.ov   = 1'b0;
                state_d.done = 1'b1;
            end
        end else if (start_i) begin
            if (op_i == OP_DADJ) begin
                state_d.acc  = adj_acc;
                state_d.cy   = adj_cy;
                state_d.breg = breg_i;
                state_d.done = 1'b1;
            end else if (breg_i == '0) begin
                state_d.acc  = acc_i;
                state_d.breg = breg_i;
                state_d.cy   = 1'b0;
                state_d.ov   = 1'b1;
                state_d.done = 1'b1;
            end else begin
                state_d.busy = 1'b1;
                state_d.cnt  = CNT_W'(DATA_W);
                state_d.rem  = '0;
                state_d.quo  = acc_i;
                state_d.dvsr = breg_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign acc_o  = state_q.acc;
    assign breg_o = state_q.breg;
    assign cy_o   = state_q.cy;
    assign ov_o   = state_q.ov;
    assign done_o = state_q.done;
    assign busy_w = state_q.busy;
    assign cnt_w  = state_q.cnt;
endmodule

// File: rtl/acc_adjdiv_chk.sv
module acc_adjdiv_chk #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              op_i,
    input logic [DATA_W-1:0] acc_i,
    input logic [DATA_W-1:0] breg_i,
    input logic              cy_i,
    input logic [DATA_W-1:0] acc_o,
    input logic [DATA_W-1:0] breg_o,
    input logic              cy_o,
    input logic              ov_o,
    input logic              done_o,
    input logic              busy,
    input logic [CNT_W-1:0]  cnt
);
    logic [DATA_W-1:0]   cap_a;
    logic [DATA_W-1:0]   cap_b;
    logic [2*DATA_W-1:0] rebuilt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_a <= '0;
            cap_b <= '0;
        end else if (start_i && op_i && !busy && breg_i != '0) begin
            cap_a <= acc_i;
            cap_b <= breg_i;
        end
    end

    assign rebuilt = acc_o * cap_b + {{DATA_W{1'b0}}, breg_o};

    // R5: an incoming carry survives decimal adjust
    a_r5_carry_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !op_i && cy_i && !busy) |=> (cy_o && done_o));

    // R7: zero divisor completes at once with overflow
    a_r7_div_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && op_i && breg_i == '0 && !busy) |=>
        (done_o && ov_o && !cy_o && acc_o == $past(acc_i) && breg_o == $past(breg_i)));

    // R6: quotient and remainder reconstruct the dividend
    a_r6_div_result: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt == CNT_W'(1)) |=>
        (done_o && !cy_o && !ov_o && rebuilt == {{DATA_W{1'b0}}, cap_a} && breg_o < cap_b));

    // R8: outputs frozen and no completion while a divide runs
    a_r8_busy_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt != CNT_W'(1)) |=>
        (!done_o && $stable(acc_o) && $stable(breg_o) && $stable(cy_o) && $stable(ov_o)));

    // R9: no completion without an accepted start or a finishing divide
    a_r9_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start_i) |=> !done_o);
endmodule

bind acc_adjdiv_unit acc_adjdiv_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .op_i    (op_i),
    .acc_i   (acc_i),
    .breg_i  (breg_i),
    .cy_i    (cy_i),
    .acc_o   (acc_o),
    .breg_o  (breg_o),
    .cy_o    (cy_o),
    .ov_o    (ov_o),
    .done_o  (done_o),
    .busy    (busy_w),
    .cnt     (cnt_w)
);

// File: tb/acc_adjdiv_unit_tb_top.sv
`timescale 1ns/1ps
module acc_adjdiv_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       op_i = 1'b0;
    logic [7:0] acc_i = '0;
    logic [7:0] breg_i = '0;
    logic       cy_i = 1'b0;
    logic       ac_i = 1'b0;
    logic [7:0] acc_o;
    logic [7:0] breg_o;
    logic       cy_o;
    logic       ov_o;
    logic       done_o;

    int checks = 0;
    int fails = 0;
    logic exp_ov = 1'b0;

    always #4 clk = ~clk;

    acc_adjdiv_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .acc_i(acc_i), .breg_i(breg_i), .cy_i(cy_i), .ac_i(ac_i),
        .acc_o(acc_o), .breg_o(breg_o), .cy_o(cy_o), .ov_o(ov_o), .done_o(done_o)
    );

    function automatic int obs();
        return {acc_o, breg_o, cy_o, ov_o, done_o};
    endfunction

    function automatic int pack(int a, int b, bit c, bit v, bit d);
        return {a[7:0], b[7:0], c, v, d};
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%05h expected=%05h (acc,b,cy,ov,done)", req, act, exp);
        end
    endtask

    task automatic launch(bit op, int a, int b, bit cy, bit ac);
        @(negedge clk);
        start_i = 1'b1; op_i = op; acc_i = a[7:0]; breg_i = b[7:0];
        cy_i = cy; ac_i = ac;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    function automatic int adj_exp(int a, bit cy, bit ac);
        int v = a;
        if (ac || (v % 16) > 9) v = v + 6;
        if (cy || v > 255 || ((v / 16) % 16) > 9) v = v + 96;
        return {(cy || v > 255), v[7:0]};
    endfunction

    initial begin
        int e;
        repeat (3) @(negedge clk);
        chk("R1 reset state", obs(), 0);
        rst_n = 1'b1;

        // R2 R3 R4 R5: exhaustive decimal adjust
        for (int a = 0; a < 256; a++) begin
            for (int f = 0; f < 4; f++) begin
                launch(1'b0, a, a ^ 8'h5A, f[0], f[1]);
                e = adj_exp(a, f[0], f[1]);
                chk("R3 R4 R5 decimal adjust", obs(), pack(e[7:0], a ^ 8'h5A, e[8], exp_ov, 1'b1));
            end
        end
        @(negedge clk);
        chk("R9 hold after decimal adjust", obs(), pack(e[7:0], 255 ^ 8'h5A, e[8], exp_ov, 1'b0));

        // R2 R6 R7 R8: divide sweep
        for (int ai = 0; ai <= 24; ai++) begin
            int a = (ai == 24) ? 255 : ai * 11;
            for (int b = 0; b < 256; b++) begin
                int q;
                int r;
                launch(1'b1, a, b, a[0], 1'b0);
                if (b == 0) begin
                    exp_ov = 1'b1;
                    chk("R7 divide by zero", obs(), pack(a, 0, 1'b0, 1'b1, 1'b1));
                    continue;
                end
                q = a / b;
                r = a % b;
                if (b % 16 == 3) begin
                    start_i = 1'b1; op_i = 1'b0; acc_i = ~a[7:0]; cy_i = 1'b1;
                end
                for (int i = 1; i <= 7; i++) begin
                    @(negedge clk);
                    start_i = 1'b0;
                end
                chk("R6 no early done", {31'b0, done_o}, 0);
                if (b % 16 == 5) begin
                    start_i = 1'b1; op_i = 1'b1; acc_i = 8'h11; breg_i = 8'h00;
                end
                @(negedge clk);
                start_i = 1'b0;
                exp_ov = 1'b0;
                chk("R6 divide result", obs(), pack(q, r, 1'b0, 1'b0, 1'b1));
                if (b % 16 == 5) begin
                    @(negedge clk);
                    chk("R8 start at completing edge ignored", obs(), pack(q, r, 1'b0, 1'b0, 1'b0));
                end
                if (b % 16 == 7) begin
                    start_i = 1'b1; op_i = 1'b0; acc_i = 8'h9A; breg_i = 8'h21;
                    cy_i = 1'b0; ac_i = 1'b0;
                    @(negedge clk);
                    start_i = 1'b0;
                    chk("R8 start while done accepted", obs(), pack(8'h00, 8'h21, 1'b1, 1'b0, 1'b1));
                end
            end
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog R9 actual=hung expected=complete");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule